// File: doc/BRIEF.md
# PCI Configuration Address Port Decoder

This block is the front end of a host bridge. It takes processor I/O cycles and sorts them into three kinds. Full doubleword accesses to the configuration address port are served from a 32-bit address register held inside the block. Accesses to the configuration data window become configuration requests when the register's enable bit is set. Every other access goes out as an ordinary I/O transaction.

The host side is a single-cycle request strobe that carries a port address, four byte enables, write data and a direction flag. Each request is answered by exactly one ready pulse with read data. Two downstream request ports stay asserted until the addressed agent returns a one-cycle done pulse with its read data. One port is for configuration requests and carries the latched bus, device, function and register fields plus a type tag. The other is the pass-through I/O port. Only one request is in flight at a time.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the address register reads as zero, and resp_ready, cfg_valid and io_valid are all low.
- R2: A write to port 0xCF8 with byte enables 4'b1111 stores the write data into the address register. No downstream request is issued.
- R3: A read of port 0xCF8 with byte enables 4'b1111 returns the address register with this layout: enable at bit 31, bus at 23:16, device at 15:11, function at 10:8, register at 7:2. Bits 30:24 and 1:0 always read as zero.
- R4: An access to ports 0xCF8-0xCFB with any byte-enable pattern other than 4'b1111 leaves the address register unchanged. It is issued on the I/O port with its own address, byte enables, direction and data.
- R5: With bit 31 of the register set, any access to 0xCFC-0xCFF issues one configuration request. The request carries the latched bus, device, function and register fields, together with the access's own byte enables, direction and data.
- R6: With bit 31 of the register clear, accesses to 0xCFC-0xCFF are issued on the I/O port.
- R7: cfg_type is 0 when the latched bus field is zero and 1 when it is non-zero.
- R8: Every request produces exactly one single-cycle resp_ready pulse. A read returns the register value or the downstream done data. A write returns zero.
- R9: Accesses to ports outside 0xCF8-0xCFF go to the I/O port.
- R10: After a doubleword write of 0x80000000 to 0xCF8, a doubleword read returns exactly 0x80000000. A previously read value written back the same way reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | I/O port address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| resp_ready | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data, valid with resp_ready |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_write | output | 1 | Configuration request direction |
| cfg_type | output | 1 | 0 = local bus, 1 = behind a bridge |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 6 | Doubleword register number |
| cfg_be | output | 4 | Byte enables of the access |
| cfg_wdata | output | 32 | Write data |
| cfg_done | input | 1 | Configuration request completed |
| cfg_rdata | input | 32 | Configuration read data |
| io_valid | output | 1 | Pass-through I/O request pending |
| io_write | output | 1 | I/O request direction |
| io_addr | output | ADDR_W | I/O port address |
| io_be | output | 4 | I/O byte enables |
| io_wdata | output | 32 | I/O write data |
| io_done | input | 1 | I/O request completed |
| io_rdata | input | 32 | I/O read data |

## Verification
The assertions assume that the host raises req_valid only while no request is outstanding. They also assume that a downstream done pulse arrives only while its own request port is asserted. The bench driver keeps to this by waiting for each ready pulse before it issues the next access. The bench responder returns exactly one done pulse, and only for a request it has observed. Under those assumptions the checker can treat any change to the address register outside a full doubleword write as an error.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  localparam int BE_W   = 4;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    K_LOCAL = 2'd0,
    K_CFG   = 2'd1,
    K_IO    = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] regn;
  } cfg_addr_t;

  function automatic cfg_addr_t unpack_addr(input logic [DATA_W-1:0] w);
    cfg_addr_t a;
    a.en   = w[31];
    a.bus  = w[23:16];
    a.dev  = w[15:11];
    a.func = w[10:8];
    a.regn = w[7:2];
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] pack_addr(input cfg_addr_t a);
    return {a.en, 7'd0, a.bus, a.dev, a.func, a.regn, 2'b00};
  endfunction

  function automatic logic is_dword(input logic [BE_W-1:0] be);
    return &be;
  endfunction

  function automatic logic type_of_bus(input logic [7:0] bus);
    return |bus;
  endfunction

endpackage

// File: rtl/cfgdec_addr_reg.sv
module cfgdec_addr_reg
  import cfgdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_addr_t         addr_q,
  output logic [DATA_W-1:0] rd_view
);
  cfg_addr_t q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= unpack_addr(wr_data);
  end

  assign addr_q  = q;
  assign rd_view = pack_addr(q);
endmodule

// File: rtl/cfgdec_classify.sv
module cfgdec_classify
  import cfgdec_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'hCFC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic              cfg_en,
  output acc_kind_e         kind
);
  localparam logic [ADDR_W-3:0] ADDR_DW = ADDR_PORT[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] DATA_DW = DATA_PORT[ADDR_W-1:2];

  logic hit_addr, hit_data;
  assign hit_addr = (addr[ADDR_W-1:2] == ADDR_DW);
  assign hit_data = (addr[ADDR_W-1:2] == DATA_DW);

  always_comb begin
    kind = K_IO;
    if (hit_addr && is_dword(be) && (addr[1:0] == 2'b00)) kind = K_LOCAL;
    else if (hit_data && cfg_en)                          kind = K_CFG;
  end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgdec_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'hCFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              resp_ready,
  output logic [31:0]       resp_rdata,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic              cfg_type,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_func,
  output logic [5:0]        cfg_reg,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_done,
  input  logic [31:0]       cfg_rdata,
  output logic              io_valid,
  output logic              io_write,
  output logic [ADDR_W-1:0] io_addr,
  output logic [3:0]        io_be,
  output logic [31:0]       io_wdata,
  input  logic              io_done,
  input  logic [31:0]       io_rdata
);
  typedef enum logic {ST_IDLE = 1'b0, ST_ACT = 1'b1} state_e;

  state_e            state_q;
  acc_kind_e         kind_q, kind_d;
  logic              h_write;
  logic [ADDR_W-1:0] h_addr;
  logic [BE_W-1:0]   h_be;
  logic [DATA_W-1:0] h_wdata;

  cfg_addr_t         addr_q;
  logic [DATA_W-1:0] addr_view;

  // Named internal events, used by the checker.
  logic busy, ev_local_wr, ev_local, ev_finish;
  logic [DATA_W-1:0] done_data;

  assign busy        = (state_q == ST_ACT);
  assign ev_local    = busy && (kind_q == K_LOCAL);
  assign ev_local_wr = ev_local && h_write;
  assign ev_finish   = ev_local
                    || (busy && (kind_q == K_CFG) && cfg_done)
                    || (busy && (kind_q == K_IO)  && io_done);

  always_comb begin
    case (kind_q)
      K_LOCAL: done_data = addr_view;
      K_CFG:   done_data = cfg_rdata;
      default: done_data = io_rdata;
    endcase
  end

  cfgdec_classify #(
    .ADDR_W(ADDR_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_cls (
    .addr(req_addr), .be(req_be), .cfg_en(addr_q.en), .kind(kind_d)
  );

  cfgdec_addr_reg u_areg (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_local_wr), .wr_data(h_wdata),
    .addr_q(addr_q), .rd_view(addr_view)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      kind_q     <= K_IO;
      h_write    <= 1'b0;
      h_addr     <= '0;
      h_be       <= '0;
      h_wdata    <= '0;
      resp_ready <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_ready <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          state_q <= ST_ACT;
          kind_q  <= kind_d;
          h_write <= req_write;
          h_addr  <= req_addr;
          h_be    <= req_be;
          h_wdata <= req_wdata;
        end
      end else if (ev_finish) begin
        state_q    <= ST_IDLE;
        resp_ready <= 1'b1;
        resp_rdata <= h_write ? '0 : done_data;
      end
    end
  end

  assign cfg_valid = busy && (kind_q == K_CFG);
  assign cfg_write = h_write;
  assign cfg_type  = type_of_bus(addr_q.bus);
  assign cfg_bus   = addr_q.bus;
  assign cfg_dev   = addr_q.dev;
  assign cfg_func  = addr_q.func;
  assign cfg_reg   = addr_q.regn;
  assign cfg_be    = h_be;
  assign cfg_wdata = h_wdata;

  assign io_valid  = busy && (kind_q == K_IO);
  assign io_write  = h_write;
  assign io_addr   = h_addr;
  assign io_be     = h_be;
  assign io_wdata  = h_wdata;
endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ev_local_wr,
  input logic        resp_ready,
  input logic        cfg_valid,
  input logic        io_valid,
  input logic        cfg_type,
  input logic [7:0]  cfg_bus,
  input logic [31:0] addr_view
);
  // R8
  a_r8_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |=> !resp_ready);
  // R8
  a_r8_ready_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |-> $past(busy));
  // R5
  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && io_valid));
  // R5
  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> addr_view[31]);
  // R7
  a_r7_type0_local: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_bus == 8'd0) |-> !cfg_type);
  // R7
  a_r7_type1_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_bus != 8'd0) |-> cfg_type);
  // R3
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_view[30:24] == 7'd0) && (addr_view[1:0] == 2'd0));
  // R4
  a_r4_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_local_wr |=> $stable(addr_view));
endmodule

bind cfg_port_decoder cfgdec_checker chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ev_local_wr(ev_local_wr),
  .resp_ready(resp_ready), .cfg_valid(cfg_valid), .io_valid(io_valid),
  .cfg_type(cfg_type), .cfg_bus(cfg_bus), .addr_view(addr_view)
);

// File: tb/cfg_port_decoder_tb_top.sv
module cfg_port_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [3:0]  req_be = 0;
  logic [31:0] req_wdata = 0;
  logic        resp_ready;
  logic [31:0] resp_rdata;
  logic        cfg_valid, cfg_write, cfg_type;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_done = 0;
  logic [31:0] cfg_rdata = 0;
  logic        io_valid, io_write;
  logic [15:0] io_addr;
  logic [3:0]  io_be;
  logic [31:0] io_wdata;
  logic        io_done = 0;
  logic [31:0] io_rdata = 0;

  cfg_port_decoder dut_i (.*);

  int checks = 0, errors = 0;
  logic [31:0] model = 0;

  logic [60:0] dq[$];
  string       dtag[$];
  logic [31:0] rq[$];
  string       rtag[$];

  function automatic logic [60:0] sig_cfg(logic wr, logic [21:0] f, logic [3:0] be, logic [31:0] wd);
    return {1'b0, wr, |f[21:14], f, be, wd};
  endfunction
  function automatic logic [60:0] sig_io(logic wr, logic [15:0] a, logic [3:0] be, logic [31:0] wd);
    return {1'b1, wr, 1'b0, 6'd0, a, be, wd};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: predicts the outcome, then issues the access.
  task automatic access(logic [15:0] a, logic [3:0] be, logic [31:0] wd, logic wr, string tag);
    logic [31:0] exp_r;
    if (a[15:2] == 14'h33E && be == 4'hF && a[1:0] == 2'b00) begin
      if (wr) model = wd & 32'h80FF_FFFC;
      exp_r = wr ? 32'h0 : model;
    end else if (a[15:2] == 14'h33F && model[31]) begin
      dq.push_back(sig_cfg(wr, model[23:2], be, wd)); dtag.push_back(tag);
      exp_r = wr ? 32'h0 : {8'hC3, model[23:2], 2'b00};
    end else begin
      dq.push_back(sig_io(wr, a, be, wd)); dtag.push_back(tag);
      exp_r = wr ? 32'h0 : {8'h5A, 4'h0, be, a};
    end
    rq.push_back(exp_r); rtag.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_be = be; req_wdata = wd; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    while (!resp_ready) @(negedge clk);
  endtask

  // Downstream responder: checks each request, answers with one done pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (cfg_valid || io_valid)) begin
        logic [60:0] got;
        got = cfg_valid ? sig_cfg(cfg_write, {cfg_bus, cfg_dev, cfg_func, cfg_reg}, cfg_be, cfg_wdata)
                        : sig_io(io_write, io_addr, io_be, io_wdata);
        if (cfg_valid && io_valid) check("R5 both ports", 64'd1, 64'd0);
        if (dq.size() == 0) check("R8 unexpected downstream request", {3'd0, got}, 64'd0);
        else check({dtag.pop_front(), " request"}, {3'd0, got}, {3'd0, dq.pop_front()});
        @(negedge clk);
        if (cfg_valid) begin
          cfg_done = 1; cfg_rdata = {8'hC3, cfg_bus, cfg_dev, cfg_func, cfg_reg, 2'b00};
        end else begin
          io_done = 1; io_rdata = {8'h5A, 4'h0, io_be, io_addr};
        end
        @(negedge clk);
        cfg_done = 0; io_done = 0;
      end
    end
  end

  // Monitor: compares every ready pulse with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && resp_ready) begin
        if (rq.size() == 0) check("R8 unexpected ready", {32'd0, resp_rdata}, 64'd0);
        else check({rtag.pop_front(), " response"}, {32'd0, resp_rdata}, {32'd0, rq.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] saved;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle outputs", {61'd0, resp_ready, cfg_valid, io_valid}, 64'd0);
    access(16'hCF8, 4'hF, 32'h0, 0, "R1 reset value");
    access(16'hCFC, 4'hF, 32'h0, 0, "R6 data window disabled");
    access(16'hCF8, 4'hF, 32'h8000_0000, 1, "R2 write enable");
    access(16'hCF8, 4'hF, 32'h0, 0, "R10 readback 80000000");
    access(16'hCF8, 4'hF, 32'hFFFF_FFFF, 1, "R2 write all ones");
    access(16'hCF8, 4'hF, 32'h0, 0, "R3 reserved bits zero");
    access(16'hCFB, 4'h8, 32'h0100_0000, 1, "R4 byte write CFB");
    access(16'hCF8, 4'hF, 32'h0, 0, "R4 register unchanged");
    access(16'hCF8, 4'h3, 32'h0000_1234, 1, "R4 word write CF8");
    access(16'hCFA, 4'hC, 32'h0, 0, "R4 word read CFA");
    access(16'hCF8, 4'hF, 32'h0, 0, "R4 register still unchanged");
    access(16'hCF8, 4'hF, 32'h8000_1910, 1, "R2 set bus0 dev3 fn1 reg4");
    access(16'hCFC, 4'hF, 32'h0, 0, "R7 type0 dword read");
    access(16'hCFD, 4'h2, 32'h0000_AB00, 1, "R5 byte write CFD");
    for (int i = 1; i < 5; i++) begin
      access(16'hCF8, 4'hF, {1'b1, 7'd0, 8'(i * 37), 5'(i), 3'(i), 6'(i * 9), 2'b00}, 1, "R5 set fields");
      access(16'hCFE, 4'hC, 32'h0, 0, "R7 type1 read");
      access(16'hCFC, 4'(i), 32'hDEAD_0000 + 32'(i), 1, "R5 partial write");
    end
    access(16'hCF8, 4'hF, 32'h0005_0000, 1, "R6 clear enable");
    access(16'hCFC, 4'hF, 32'h0, 0, "R6 data window to IO");
    access(16'hCFF, 4'h8, 32'h7700_0000, 1, "R6 byte write to IO");
    access(16'h0080, 4'h1, 32'h0000_0042, 1, "R9 other port write");
    access(16'h03F8, 4'hF, 32'h0, 0, "R9 other port read");
    access(16'hCF4, 4'hF, 32'h0, 0, "R9 neighbour port");
    saved = model;
    access(16'hCF8, 4'hF, 32'h8000_0000, 1, "R10 probe write");
    access(16'hCF8, 4'hF, 32'h0, 0, "R10 probe read");
    access(16'hCF8, 4'hF, saved, 1, "R10 restore write");
    access(16'hCF8, 4'hF, 32'h0, 0, "R10 restored value");
    repeat (4) @(negedge clk);
    check("R8 all responses seen", 64'(rq.size()), 64'd0);
    check("R8 all requests seen", 64'(dq.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule